// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns a handful of register writes into a complete operation on an 8-bit asynchronous NAND flash bus. Software first loads four words: a command word, two address words and a packet word. It then writes a one-hot value to the start register. The sequencer takes a snapshot of the loaded fields and drives the bus by itself. It emits the first opcode with the command latch strobe, then the address bytes with the address latch strobe, then a second opcode where the operation type calls for one. After that it waits on the ready/busy line of the selected chip and raises a completion event.

A status operation is handled differently. It issues its opcode and then performs a single read strobe. The returned byte goes into a status register. Ready/busy lines raise no interrupt; each line shows up as one bit in a ready register that software polls. A busy flag is available both as a port and as a register. Start writes that arrive while an operation is running are discarded.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the block is idle. `busy` is 0, every `nand_ce_n` bit is 1, `nand_we_n` and `nand_re_n` are 1, `nand_cle` and `nand_ale` are 0, the event word (index 5) reads 0 and the timing word (index 8) reads 2.
- R2: Word indices 0 (command), 1 (address low), 2 (address high) and 3 (packet) read back exactly the last value written to them.
- R3: An operation starts only when index 4 is written while the block is idle and the value has exactly one of these bits set: bit 0 page read, 2 erase, 3 status, 4 page program, 6 read ID, 7 parameter read, 8 reset, 9 get feature, 10 set feature. Any other value is ignored and leaves `busy` at 0 with no bus activity.
- R4: Every write-strobe bus cycle holds `nand_we_n` low for P clocks and then high for P clocks, with the data driven throughout. P is timing word bits [3:0], and 0 counts as 1. The first cycle carries command bits [7:0] with `nand_cle` high and `nand_ale` low.
- R5: The number of address cycles is command bits [30:28], clamped to 5. Address cycles have `nand_ale` high and `nand_cle` low. Bytes 0..3 come from the address-low word with the least significant byte first; byte 4 is address-high bits [7:0].
- R6: One further command cycle carrying command bits [15:8] follows the addresses only for page read, page program and erase. No other operation emits it.
- R7: During an operation, only `nand_ce_n[k]` is low, where k is address-high bits [31:30]. Apart from a status operation, completion waits until `nand_rb_n[k]` is high; the check starts four clocks after the last bus cycle.
- R8: A status operation emits its opcode with no address cycles, then one `nand_re_n` low pulse of P clocks, and performs no ready/busy wait. The byte on `nand_dq_i` in the last low clock is stored in index 7 bits [7:0].
- R9: Completion sets bit 2 of the event word (index 5). Writing that word with bit 2 set clears the bit.
- R10: While `busy` is 1, writes to index 4 are ignored. `busy` is also readable at index 9 bit 0.
- R11: Index 6 bit i reads 1 when `nand_rb_n[i]` is high, after a two-clock synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Operation in progress |
| nand_ce_n | output | NCS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus data drive enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_n | input | NCS | Ready/busy lines, low means busy |

## Verification
The bench records every strobe on the bus together with the latch signals, the data and the chip enables. It then compares the record against sequences built from the requirements.

- **Address count.** An address count of 7 must come out as five cycles. A design that fails to clamp would emit extra address bytes drawn from a wrong field.
- **Second opcode.** Read ID is given a non-zero second opcode. A design that sends it for every operation type adds a stray cycle that the bench sees.
- **Ready/busy wait.** An erase is issued on chip 2 while that chip's line is held low. A design that ignores ready/busy, or watches the wrong line, would report completion early.
- **Start while busy.** A start write made during that wait must not show up as any extra bus cycle.
- **Status read.** A status operation is loaded with a non-zero address count, yet must show no address cycles.
- **Strobe timing.** A changed pulse width must appear as both the low and the high width of the strobe.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RI_CMD   = 4'd0;
    localparam logic [REG_AW-1:0] RI_ADRL  = 4'd1;
    localparam logic [REG_AW-1:0] RI_ADRH  = 4'd2;
    localparam logic [REG_AW-1:0] RI_PKT   = 4'd3;
    localparam logic [REG_AW-1:0] RI_GO    = 4'd4;
    localparam logic [REG_AW-1:0] RI_EVT   = 4'd5;
    localparam logic [REG_AW-1:0] RI_RDY   = 4'd6;
    localparam logic [REG_AW-1:0] RI_FST   = 4'd7;
    localparam logic [REG_AW-1:0] RI_TIM   = 4'd8;
    localparam logic [REG_AW-1:0] RI_BUSY  = 4'd9;

    localparam int MAX_ADDR = 5;
    localparam int EVT_DONE_BIT = 2;

    typedef enum logic [3:0] {
        OP_NONE, OP_PGRD, OP_ERASE, OP_STAT, OP_PGPROG,
        OP_RDID, OP_PARAM, OP_RST, OP_GETF, OP_SETF
    } op_kind_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD1, PH_ADDR, PH_CMD2, PH_STAT, PH_SETTLE, PH_WAIT, PH_DONE
    } phase_t;

    typedef struct packed {
        op_kind_t    kind;
        logic [7:0]  opc1;
        logic [7:0]  opc2;
        logic [2:0]  naddr;
        logic [39:0] abytes;
        logic [1:0]  cs;
    } op_ctx_t;

    function automatic op_kind_t decode_go(input logic [31:0] v);
        case (v)
            32'h0000_0001: return OP_PGRD;
            32'h0000_0004: return OP_ERASE;
            32'h0000_0008: return OP_STAT;
            32'h0000_0010: return OP_PGPROG;
            32'h0000_0040: return OP_RDID;
            32'h0000_0080: return OP_PARAM;
            32'h0000_0100: return OP_RST;
            32'h0000_0200: return OP_GETF;
            32'h0000_0400: return OP_SETF;
            default:       return OP_NONE;
        endcase
    endfunction

    function automatic logic has_second_opc(input op_kind_t k);
        return (k == OP_PGRD) || (k == OP_PGPROG) || (k == OP_ERASE);
    endfunction

    function automatic logic [2:0] clamp_naddr(input logic [2:0] n);
        return (n > 3'(MAX_ADDR)) ? 3'(MAX_ADDR) : n;
    endfunction

endpackage

// File: rtl/nseq_rb_sync.sv
module nseq_rb_sync #(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCS-1:0] rb_n,
    output logic [NCS-1:0] rdy
);
    for (genvar i = 0; i < NCS; i++) begin : g_line
        logic [1:0] stage;
        always_ff @(posedge clk) begin
            if (rst) stage <= 2'b00;
            else     stage <= {stage[0], rb_n[i]};
        end
        assign rdy[i] = stage[1];
    end
endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
    parameter int PW_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PW_W-1:0] pw,
    output logic            strobe_lo,
    output logic            strobe_mid,
    output logic            strobe_last
);
    localparam int CW = PW_W + 1;

    logic [PW_W-1:0] pw_eff;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   half;
    logic [CW-1:0]   full;

    assign pw_eff = (pw == '0) ? PW_W'(1) : pw;
    assign half   = {1'b0, pw_eff};
    assign full   = {pw_eff, 1'b0};

    assign strobe_lo   = run && (cnt < half);
    assign strobe_mid  = run && (cnt == half - CW'(1));
    assign strobe_last = run && (cnt == full - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || strobe_last) cnt <= '0;
        else                            cnt <= cnt + CW'(1);
    end

    // R4: the count never runs past the end of one bus cycle
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < full));
endmodule

// File: rtl/nseq_regs.sv
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int PW_W   = 4,
    parameter int DEF_PW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              seq_busy,
    input  logic              done_pulse,
    input  logic              fstat_we,
    input  logic [7:0]        fstat_val,
    input  logic [NCS-1:0]    rdy,
    output logic [31:0]       cmd_w,
    output logic [31:0]       adrl_w,
    output logic [31:0]       adrh_w,
    output logic [PW_W-1:0]   pw,
    output logic              go_pulse,
    output logic [31:0]       go_word
);
    logic [31:0] pkt_w;
    logic [7:0]  fstat;
    logic        evt_done;

    assign go_pulse = reg_we && (reg_addr == RI_GO);
    assign go_word  = reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_w  <= '0;
            adrl_w <= '0;
            adrh_w <= '0;
            pkt_w  <= '0;
            pw     <= PW_W'(DEF_PW);
        end else if (reg_we) begin
            case (reg_addr)
                RI_CMD:  cmd_w  <= reg_wdata;
                RI_ADRL: adrl_w <= reg_wdata;
                RI_ADRH: adrh_w <= reg_wdata;
                RI_PKT:  pkt_w  <= reg_wdata;
                RI_TIM:  pw     <= reg_wdata[PW_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           fstat <= '0;
        else if (fstat_we) fstat <= fstat_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            evt_done <= 1'b0;
        else if (done_pulse)
            evt_done <= 1'b1;
        else if (reg_we && reg_addr == RI_EVT && reg_wdata[EVT_DONE_BIT])
            evt_done <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RI_CMD:  reg_rdata = cmd_w;
            RI_ADRL: reg_rdata = adrl_w;
            RI_ADRH: reg_rdata = adrh_w;
            RI_PKT:  reg_rdata = pkt_w;
            RI_EVT:  reg_rdata[EVT_DONE_BIT] = evt_done;
            RI_RDY:  reg_rdata[NCS-1:0] = rdy;
            RI_FST:  reg_rdata[7:0] = fstat;
            RI_TIM:  reg_rdata[PW_W-1:0] = pw;
            RI_BUSY: reg_rdata[0] = seq_busy;
            default: reg_rdata = '0;
        endcase
    end

    // R9: a completion is always visible in the event word afterwards
    assert_done_evt_R9: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> evt_done);
endmodule

// File: rtl/nseq_core.sv
module nseq_core
    import nseq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int SETTLE = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go_pulse,
    input  logic [31:0]    go_word,
    input  logic [7:0]     opc1_in,
    input  logic [7:0]     opc2_in,
    input  logic [2:0]     naddr_in,
    input  logic [39:0]    abytes_in,
    input  logic [1:0]     cs_in,
    input  logic           strobe_lo,
    input  logic           strobe_mid,
    input  logic           strobe_last,
    input  logic [NCS-1:0] rdy,
    input  logic [7:0]     dq_i,
    output logic           run,
    output logic           busy,
    output logic           done_pulse,
    output logic           fstat_we,
    output logic [7:0]     fstat_val,
    output logic [NCS-1:0] ce_n,
    output logic           cle,
    output logic           ale,
    output logic           we_n,
    output logic           re_n,
    output logic           dq_oe,
    output logic [7:0]     dq_o
);
    localparam int SW = $clog2(SETTLE + 1);

    phase_t          phase;
    op_ctx_t         ctx;
    logic [2:0]      ai;
    logic [SW-1:0]   settle_cnt;
    logic [NCS-1:0]  cs_hot;
    logic            rdy_sel;
    logic            wr_phase;
    op_kind_t        go_kind;

    assign go_kind = decode_go(go_word);

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_hot[i] = (ctx.cs == 2'(i));
        assign ce_n[i]   = ~(busy & cs_hot[i]);
    end
    assign rdy_sel = |(rdy & cs_hot);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            ctx        <= '0;
            ai         <= '0;
            settle_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (go_pulse && go_kind != OP_NONE) begin
                        ctx.kind   <= go_kind;
                        ctx.opc1   <= opc1_in;
                        ctx.opc2   <= opc2_in;
                        ctx.naddr  <= clamp_naddr(naddr_in);
                        ctx.abytes <= abytes_in;
                        ctx.cs     <= cs_in;
                        phase      <= PH_CMD1;
                    end
                end
                PH_CMD1: begin
                    if (strobe_last) begin
                        ai <= '0;
                        if (ctx.kind == OP_STAT)         phase <= PH_STAT;
                        else if (ctx.naddr != '0)        phase <= PH_ADDR;
                        else if (has_second_opc(ctx.kind)) phase <= PH_CMD2;
                        else                             phase <= PH_SETTLE;
                    end
                end
                PH_ADDR: begin
                    if (strobe_last) begin
                        if (ai == ctx.naddr - 3'd1)
                            phase <= has_second_opc(ctx.kind) ? PH_CMD2 : PH_SETTLE;
                        else
                            ai <= ai + 3'd1;
                    end
                end
                PH_CMD2: begin
                    if (strobe_last) phase <= PH_SETTLE;
                end
                PH_STAT: begin
                    if (strobe_last) phase <= PH_DONE;
                end
                PH_SETTLE: begin
                    if (settle_cnt == SW'(SETTLE - 1)) begin
                        settle_cnt <= '0;
                        phase      <= PH_WAIT;
                    end else begin
                        settle_cnt <= settle_cnt + SW'(1);
                    end
                end
                PH_WAIT: begin
                    if (rdy_sel) phase <= PH_DONE;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign wr_phase   = (phase == PH_CMD1) || (phase == PH_ADDR) || (phase == PH_CMD2);
    assign run        = wr_phase || (phase == PH_STAT);
    assign busy       = (phase != PH_IDLE);
    assign done_pulse = (phase == PH_DONE);
    assign fstat_we   = (phase == PH_STAT) && strobe_mid;
    assign fstat_val  = dq_i;

    assign cle   = (phase == PH_CMD1) || (phase == PH_CMD2);
    assign ale   = (phase == PH_ADDR);
    assign we_n  = ~(wr_phase && strobe_lo);
    assign re_n  = ~((phase == PH_STAT) && strobe_lo);
    assign dq_oe = wr_phase;

    always_comb begin
        case (phase)
            PH_CMD1: dq_o = ctx.opc1;
            PH_CMD2: dq_o = ctx.opc2;
            PH_ADDR: dq_o = ctx.abytes[{ai, 3'b000} +: 8];
            default: dq_o = 8'h00;
        endcase
    end

    // R5: the two latch strobes are never raised together
    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));
    // R7: at most one chip enable is active
    assert_ce_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n));
    // R4: a write strobe only ever comes with a latch strobe
    assert_we_latch_R4: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (cle || ale));
    // R8: a read strobe is alone on the bus
    assert_re_alone_R8: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> (!cle && !ale && !dq_oe && we_n));
    // R10: a start request during an operation leaves the snapshot alone
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && go_pulse) |=> $stable(ctx));
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nseq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int PW_W   = 4,
    parameter int DEF_PW = 2,
    parameter int SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic [NCS-1:0]    nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic [NCS-1:0]    nand_rb_n
);
    logic [31:0]     cmd_w, adrl_w, adrh_w, go_word;
    logic [PW_W-1:0] pw;
    logic            go_pulse, done_pulse, fstat_we, run;
    logic [7:0]      fstat_val;
    logic [NCS-1:0]  rdy;
    logic            strobe_lo, strobe_mid, strobe_last;

    nseq_rb_sync #(.NCS(NCS)) u_sync (
        .clk(clk), .rst(rst), .rb_n(nand_rb_n), .rdy(rdy)
    );

    nseq_regs #(.NCS(NCS), .PW_W(PW_W), .DEF_PW(DEF_PW)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_busy(busy),
        .done_pulse(done_pulse), .fstat_we(fstat_we), .fstat_val(fstat_val),
        .rdy(rdy), .cmd_w(cmd_w), .adrl_w(adrl_w), .adrh_w(adrh_w), .pw(pw),
        .go_pulse(go_pulse), .go_word(go_word)
    );

    nseq_strobe #(.PW_W(PW_W)) u_strobe (
        .clk(clk), .rst(rst), .run(run), .pw(pw), .strobe_lo(strobe_lo),
        .strobe_mid(strobe_mid), .strobe_last(strobe_last)
    );

    nseq_core #(.NCS(NCS), .SETTLE(SETTLE)) u_core (
        .clk(clk), .rst(rst), .go_pulse(go_pulse), .go_word(go_word),
        .opc1_in(cmd_w[7:0]), .opc2_in(cmd_w[15:8]), .naddr_in(cmd_w[30:28]),
        .abytes_in({adrh_w[7:0], adrl_w}), .cs_in(adrh_w[31:30]),
        .strobe_lo(strobe_lo), .strobe_mid(strobe_mid), .strobe_last(strobe_last),
        .rdy(rdy), .dq_i(nand_dq_i), .run(run), .busy(busy),
        .done_pulse(done_pulse), .fstat_we(fstat_we), .fstat_val(fstat_val),
        .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
        .re_n(nand_re_n), .dq_oe(nand_dq_oe), .dq_o(nand_dq_o)
    );
endmodule

// File: tb/tb_nand_op_seq.sv
module tb_nand_op_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  stat_val = 8'h00;
    logic [3:0]  nand_rb_n = 4'hF;

    always #4 clk = ~clk;

    nand_op_seq dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(stat_val), .nand_rb_n(nand_rb_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    // bus recorder, sampled on the falling clock edge
    logic [7:0] lg_dq  [0:63];
    logic       lg_cle [0:63];
    logic       lg_ale [0:63];
    logic [3:0] lg_ce  [0:63];
    int lg_n = 0;
    int re_pulses = 0;
    int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
    logic prev_we = 1'b1, prev_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0;
    logic [7:0] p_dq = '0;
    logic [3:0] p_ce = 4'hF;

    always @(negedge clk) begin
        if (!nand_we_n) begin
            p_cle = nand_cle; p_ale = nand_ale; p_dq = nand_dq_o; p_ce = nand_ce_n;
            if (prev_we) begin last_hi = hi_run; lo_run = 0; end
            lo_run++;
        end else begin
            if (!prev_we) begin
                last_lo = lo_run; hi_run = 0;
                if (lg_n < 64) begin
                    lg_dq[lg_n] = p_dq; lg_cle[lg_n] = p_cle;
                    lg_ale[lg_n] = p_ale; lg_ce[lg_n] = p_ce;
                end
                lg_n++;
            end
            hi_run++;
        end
        if (nand_re_n && !prev_re) re_pulses++;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        @(negedge clk);
        while (busy && t < 3000) begin @(negedge clk); t++; end
        chk(req, {31'b0, busy}, 32'd0);
    endtask

    function automatic bit exp_second(input logic [31:0] g);
        return (g == 32'h1) || (g == 32'h4) || (g == 32'h10);
    endfunction

    localparam int NV = 6;
    localparam logic [31:0] V_GO   [NV] = '{32'h1, 32'h10, 32'h4, 32'h40, 32'h100, 32'h200};
    localparam logic [2:0]  V_NA   [NV] = '{3'd5, 3'd4, 3'd3, 3'd1, 3'd0, 3'd7};
    localparam logic [31:0] V_ADRL [NV] = '{32'h44332211, 32'hA3A2A1A0, 32'h00C2C1C0,
                                            32'h00000020, 32'h0, 32'h04030201};
    localparam logic [31:0] V_ADRH [NV] = '{32'h40000055, 32'h800000EE, 32'hC0000000,
                                            32'h0, 32'h0, 32'h00000005};
    localparam logic [7:0]  V_C1   [NV] = '{8'h00, 8'h80, 8'h60, 8'h90, 8'hFF, 8'hEE};
    localparam logic [7:0]  V_C2   [NV] = '{8'h30, 8'h10, 8'hD0, 8'hAA, 8'h55, 8'h77};

    initial begin
        logic [31:0] d;
        int base, na, expn, re0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 ce_n", {28'b0, nand_ce_n}, 32'hF);
        chk("R1 strobes", {28'b0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'b1100);
        rd(4'd5, d); chk("R1 evt", d, 32'd0);
        rd(4'd8, d); chk("R1 timing", d, 32'd2);
        // R11 ready lines
        rd(4'd6, d); chk("R11 all ready", d, 32'hF);
        // R2 readback
        wr(4'd0, 32'h12345678); rd(4'd0, d); chk("R2 cmd", d, 32'h12345678);
        wr(4'd1, 32'hCAFEF00D); rd(4'd1, d); chk("R2 adrl", d, 32'hCAFEF00D);
        wr(4'd2, 32'h8BADBEEF); rd(4'd2, d); chk("R2 adrh", d, 32'h8BADBEEF);
        wr(4'd3, 32'h00C0FFEE); rd(4'd3, d); chk("R2 pkt", d, 32'h00C0FFEE);
        // R3 invalid start values
        base = lg_n;
        wr(4'd4, 32'h3); repeat (3) @(negedge clk);
        chk("R3 two bits", {31'b0, busy}, 32'd0);
        wr(4'd4, 32'h2); repeat (3) @(negedge clk);
        chk("R3 unused bit", {31'b0, busy}, 32'd0);
        chk("R3 no cycles", 32'(lg_n - base), 32'd0);

        // table of operations
        for (int v = 0; v < NV; v++) begin
            base = lg_n;
            wr(4'd0, {1'b0, V_NA[v], 12'h000, V_C2[v], V_C1[v]});
            wr(4'd1, V_ADRL[v]);
            wr(4'd2, V_ADRH[v]);
            wr(4'd4, V_GO[v]);
            wait_idle("R7 completes");
            na = (V_NA[v] > 3'd5) ? 5 : int'(V_NA[v]);
            expn = 1 + na + (exp_second(V_GO[v]) ? 1 : 0);
            chk("R6 cycle count", 32'(lg_n - base), 32'(expn));
            chk("R4 first cmd", {23'b0, lg_cle[base], lg_ale[base], lg_dq[base]},
                {23'b0, 1'b1, 1'b0, V_C1[v]});
            chk("R7 ce select", {28'b0, lg_ce[base]},
                {28'b0, ~(4'b0001 << V_ADRH[v][31:30])});
            for (int i = 0; i < na; i++) begin
                chk("R5 addr byte", {23'b0, lg_cle[base+1+i], lg_ale[base+1+i], lg_dq[base+1+i]},
                    {23'b0, 1'b0, 1'b1, (i < 4) ? V_ADRL[v][8*i +: 8] : V_ADRH[v][7:0]});
            end
            if (exp_second(V_GO[v]))
                chk("R6 second opc", {23'b0, lg_cle[base+expn-1], lg_ale[base+expn-1], lg_dq[base+expn-1]},
                    {23'b0, 1'b1, 1'b0, V_C2[v]});
            rd(4'd5, d); chk("R9 done set", d, 32'h4);
            wr(4'd5, 32'h4);
            rd(4'd5, d); chk("R9 done clear", d, 32'h0);
        end

        // R4 pulse width 3
        wr(4'd8, 32'd3);
        wr(4'd0, {1'b0, 3'd1, 12'h0, 8'h00, 8'h90});
        wr(4'd4, 32'h40);
        wait_idle("R4 idle");
        chk("R4 low width", 32'(last_lo), 32'd3);
        chk("R4 high width", 32'(last_hi), 32'd3);
        wr(4'd8, 32'd2);
        wr(4'd5, 32'h4);

        // R8 status read with nonzero address count
        stat_val = 8'hE1;
        base = lg_n; re0 = re_pulses;
        wr(4'd0, {1'b0, 3'd2, 12'h0, 8'h00, 8'h70});
        wr(4'd4, 32'h8);
        wait_idle("R8 idle");
        chk("R8 one cycle", 32'(lg_n - base), 32'd1);
        chk("R8 opcode", {24'b0, lg_dq[base]}, 32'h70);
        chk("R8 one read", 32'(re_pulses - re0), 32'd1);
        rd(4'd7, d); chk("R8 status byte", d, 32'hE1);
        rd(4'd5, d); chk("R9 status done", d, 32'h4);
        wr(4'd5, 32'h4);
        stat_val = 8'h3C;

        // R7 / R10 / R11 erase on chip 2 held busy
        nand_rb_n = 4'b1011;
        base = lg_n; re0 = re_pulses;
        wr(4'd0, {1'b0, 3'd3, 12'h0, 8'hD0, 8'h60});
        wr(4'd1, 32'h00010203);
        wr(4'd2, 32'h80000000);
        wr(4'd4, 32'h4);
        repeat (80) @(negedge clk);
        chk("R7 waits on line", {31'b0, busy}, 32'd1);
        chk("R7 cycles sent", 32'(lg_n - base), 32'd5);
        rd(4'd6, d); chk("R11 line low", d, 32'hB);
        rd(4'd9, d); chk("R10 busy reg", d, 32'd1);
        wr(4'd4, 32'h8);
        repeat (20) @(negedge clk);
        chk("R10 still busy", {31'b0, busy}, 32'd1);
        nand_rb_n = 4'hF;
        wait_idle("R7 release");
        chk("R10 no extra cycles", 32'(lg_n - base), 32'd5);
        chk("R10 no read", 32'(re_pulses - re0), 32'd0);
        rd(4'd7, d); chk("R10 status kept", d, 32'hE1);
        rd(4'd9, d); chk("R10 busy reg idle", d, 32'd0);

        finish_run();
    end
endmodule